// File: doc/BRIEF.md
# Interrupt Controller Error Status Unit

This unit tracks error events for a local interrupt controller. Link-level checksum and accept failures arrive as one-cycle strobes. The unit also detects three kinds of error itself: out-of-range vectors on interrupts sent or received, entry writes that carry an out-of-range vector, and accesses to offsets with no register. Every event sets a bit in a hidden accumulator.

Software sees these errors only through the status register, and it refreshes that register by writing to it. The value written does not matter. The write copies the accumulator into the readable status and starts a new collection period. A write followed by a read therefore returns the errors gathered since the previous write.

An error entry holds a vector and a mask. When the accumulator goes from empty to non-empty and the entry is unmasked, the unit sends a single interrupt request that carries the entry's vector. The register window also holds a parameterised number of other interrupt-source entries. The unit keeps these only so that it can check the vectors written into them.

Top module: `lic_err_unit`

## Requirements
- R1: After reset the status register and accumulator are zero, `err_irq` is low, and the error entry and every source entry read back as masked with vector zero (0x0001_0000).
- R2: Register map in word offsets: 0 is the status register, 1 is the error entry, and 2 to 1+NUM_LVT are the source entries. An entry holds its vector in bits [7:0] and its mask in bit 16, and reads back exactly what was written to those fields.
- R3: Status bits: 0 send checksum, 1 receive checksum, 2 send accept, 3 receive accept, 5 sent illegal vector, 6 received illegal vector, 7 illegal register address. Strobes `ev_link[3:0]` feed bits 0 to 3 in that order. Bit 4 and bits above 7 always read zero.
- R4: Events OR into the accumulator and are not visible in the status register until it is written.
- R5: A write to offset 0 loads the status register with the accumulator and the written data is ignored. The accumulator is then left holding only the events that arrived in the same cycle as the write.
- R6: `tx_valid` with `tx_vec` below ILLEGAL_LIMIT (16) sets bit 5. A vector of 16 or more sets nothing.
- R7: `rx_valid` with `rx_vec` below ILLEGAL_LIMIT sets bit 6.
- R8: A write of a vector below ILLEGAL_LIMIT to the error entry or to any source entry sets bit 6, whether the written mask is set or clear.
- R9: A read or write at an offset above 1+NUM_LVT sets bit 7. Such a read returns zero.
- R10: `err_irq` pulses for one cycle in the cycle after the accumulator goes from empty to non-empty, but only if the error entry is unmasked. `err_irq_vec` then carries the entry's vector. Further events added to a non-empty accumulator raise no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word offset of the access |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data for `addr`, combinational |
| ev_link | input | 4 | Checksum and accept error strobes |
| tx_valid | input | 1 | An interrupt is being sent |
| tx_vec | input | 8 | Vector of the interrupt being sent |
| rx_valid | input | 1 | An interrupt was received |
| rx_vec | input | 8 | Vector of the received interrupt |
| err_irq | output | 1 | Error interrupt request pulse |
| err_irq_vec | output | 8 | Vector that goes with `err_irq` |

## Verification
The bench builds the unit with NUM_LVT=3 and ADDR_W=3. With these values offsets 2 to 4 are source entries and offsets 5 to 7 are unimplemented, so the 3-bit address space reaches the illegal-address path in both directions. ILLEGAL_LIMIT stays at 16, which puts vectors 0x0F and 0x10 on either side of the boundary. A scoreboard queue holds the expected interrupt vectors, so any missing or extra request is caught, including the case of a status write in the same cycle as a new event.

// File: rtl/lic_err_pkg.sv
package lic_err_pkg;
  localparam int VEC_W    = 8;
  localparam int ERR_W    = 8;
  localparam int MASK_BIT = 16;

  // Status bit positions (software decodes these)
  localparam int B_TX_CKS   = 0;
  localparam int B_RX_CKS   = 1;
  localparam int B_TX_ACC   = 2;
  localparam int B_RX_ACC   = 3;
  localparam int B_RSVD     = 4;
  localparam int B_TX_ILL   = 5;
  localparam int B_RX_ILL   = 6;
  localparam int B_BAD_ADDR = 7;

  typedef struct packed {
    logic             masked;
    logic [VEC_W-1:0] vec;
  } lvt_entry_t;

  function automatic logic vec_is_illegal(input logic [VEC_W-1:0] v, input int limit);
    return int'(v) < limit;
  endfunction
endpackage

// File: rtl/lic_err_decode.sv
module lic_err_decode #(
  parameter int ADDR_W  = 4,
  parameter int NUM_LVT = 5
) (
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  output logic               sel_esr,
  output logic               sel_eent,
  output logic               esr_wr,
  output logic               eent_wr,
  output logic [NUM_LVT-1:0] lvt_sel,
  output logic [NUM_LVT-1:0] lvt_wr,
  output logic               bad_access
);
  localparam int OFF_ESR   = 0;
  localparam int OFF_EENT  = 1;
  localparam int FIRST_LVT = 2;
  localparam int LAST_OFF  = FIRST_LVT + NUM_LVT - 1;

  assign sel_esr  = (int'(addr) == OFF_ESR);
  assign sel_eent = (int'(addr) == OFF_EENT);
  assign esr_wr   = wr_en & sel_esr;
  assign eent_wr  = wr_en & sel_eent;

  for (genvar g = 0; g < NUM_LVT; g++) begin : g_sel
    assign lvt_sel[g] = (int'(addr) == FIRST_LVT + g);
    assign lvt_wr[g]  = wr_en & lvt_sel[g];
  end

  assign bad_access = (wr_en | rd_en) & (int'(addr) > LAST_OFF);
endmodule

// File: rtl/lic_err_lvt_bank.sv
module lic_err_lvt_bank
  import lic_err_pkg::*;
#(
  parameter int NUM_LVT       = 5,
  parameter int DATA_W        = 32,
  parameter int ILLEGAL_LIMIT = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               eent_wr,
  input  logic [NUM_LVT-1:0] lvt_wr,
  input  logic [NUM_LVT-1:0] lvt_sel,
  input  logic [DATA_W-1:0]  wdata,
  output lvt_entry_t         eent_q,
  output logic [DATA_W-1:0]  eent_rdata,
  output logic [DATA_W-1:0]  lvt_rdata,
  output logic               bad_vec_wr
);
  function automatic logic [DATA_W-1:0] to_word(input lvt_entry_t e);
    logic [DATA_W-1:0] w;
    w = '0;
    w[VEC_W-1:0] = e.vec;
    w[MASK_BIT]  = e.masked;
    return w;
  endfunction

  lvt_entry_t wr_entry;
  lvt_entry_t ent_q [NUM_LVT];
  logic       unused_wdata;

  assign wr_entry.masked = wdata[MASK_BIT];
  assign wr_entry.vec    = wdata[VEC_W-1:0];
  assign unused_wdata    = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eent_q.masked <= 1'b1;
      eent_q.vec    <= '0;
      for (int i = 0; i < NUM_LVT; i++) begin
        ent_q[i].masked <= 1'b1;
        ent_q[i].vec    <= '0;
      end
    end else begin
      if (eent_wr) eent_q <= wr_entry;
      for (int i = 0; i < NUM_LVT; i++)
        if (lvt_wr[i]) ent_q[i] <= wr_entry;
    end
  end

  always_comb begin
    lvt_rdata = '0;
    for (int i = 0; i < NUM_LVT; i++)
      if (lvt_sel[i]) lvt_rdata = lvt_rdata | to_word(ent_q[i]);
  end

  assign eent_rdata = to_word(eent_q);
  assign bad_vec_wr = (eent_wr | (|lvt_wr)) & vec_is_illegal(wr_entry.vec, ILLEGAL_LIMIT);
endmodule

// File: rtl/lic_err_accum.sv
module lic_err_accum
  import lic_err_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] new_ev,
  input  logic             esr_wr,
  input  logic             irq_en,
  input  logic [VEC_W-1:0] irq_vec,
  output logic [ERR_W-1:0] acc_q,
  output logic [ERR_W-1:0] status_q,
  output logic             acc_rise,
  output logic             err_irq,
  output logic [VEC_W-1:0] err_irq_vec
);
  logic [ERR_W-1:0] acc_d;

  // A status write starts a fresh period that keeps same-cycle events
  assign acc_d    = esr_wr ? new_ev : (acc_q | new_ev);
  assign acc_rise = (acc_q == '0) && (acc_d != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      status_q    <= '0;
      err_irq     <= 1'b0;
      err_irq_vec <= '0;
    end else begin
      acc_q   <= acc_d;
      err_irq <= acc_rise & irq_en;
      if (esr_wr) status_q <= acc_q;
      if (acc_rise & irq_en) err_irq_vec <= irq_vec;
    end
  end
endmodule

// File: rtl/lic_err_unit.sv
module lic_err_unit
  import lic_err_pkg::*;
#(
  parameter int ADDR_W        = 4,
  parameter int DATA_W        = 32,
  parameter int NUM_LVT       = 5,
  parameter int ILLEGAL_LIMIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [3:0]        ev_link,
  input  logic              tx_valid,
  input  logic [7:0]        tx_vec,
  input  logic              rx_valid,
  input  logic [7:0]        rx_vec,
  output logic              err_irq,
  output logic [7:0]        err_irq_vec
);
  logic               sel_esr, sel_eent, esr_wr, eent_wr, bad_access;
  logic [NUM_LVT-1:0] lvt_sel, lvt_wr;
  lvt_entry_t         eent_q;
  logic [DATA_W-1:0]  eent_rdata, lvt_rdata;
  logic               bad_vec_wr, irq_en, acc_rise;
  logic [ERR_W-1:0]   new_ev, acc_q, status_q;

  lic_err_decode #(.ADDR_W(ADDR_W), .NUM_LVT(NUM_LVT)) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .sel_esr(sel_esr), .sel_eent(sel_eent), .esr_wr(esr_wr), .eent_wr(eent_wr),
    .lvt_sel(lvt_sel), .lvt_wr(lvt_wr), .bad_access(bad_access)
  );

  lic_err_lvt_bank #(.NUM_LVT(NUM_LVT), .DATA_W(DATA_W), .ILLEGAL_LIMIT(ILLEGAL_LIMIT)) u_bank (
    .clk(clk), .rst_n(rst_n), .eent_wr(eent_wr), .lvt_wr(lvt_wr), .lvt_sel(lvt_sel),
    .wdata(wdata), .eent_q(eent_q), .eent_rdata(eent_rdata), .lvt_rdata(lvt_rdata),
    .bad_vec_wr(bad_vec_wr)
  );

  always_comb begin
    new_ev             = '0;
    new_ev[B_TX_CKS]   = ev_link[0];
    new_ev[B_RX_CKS]   = ev_link[1];
    new_ev[B_TX_ACC]   = ev_link[2];
    new_ev[B_RX_ACC]   = ev_link[3];
    new_ev[B_TX_ILL]   = tx_valid & vec_is_illegal(tx_vec, ILLEGAL_LIMIT);
    new_ev[B_RX_ILL]   = (rx_valid & vec_is_illegal(rx_vec, ILLEGAL_LIMIT)) | bad_vec_wr;
    new_ev[B_BAD_ADDR] = bad_access;
  end

  assign irq_en = ~eent_q.masked;

  lic_err_accum u_acc (
    .clk(clk), .rst_n(rst_n), .new_ev(new_ev), .esr_wr(esr_wr), .irq_en(irq_en),
    .irq_vec(eent_q.vec), .acc_q(acc_q), .status_q(status_q), .acc_rise(acc_rise),
    .err_irq(err_irq), .err_irq_vec(err_irq_vec)
  );

  always_comb begin
    rdata = '0;
    if (sel_esr)       rdata[ERR_W-1:0] = status_q;
    else if (sel_eent) rdata = eent_rdata;
    else               rdata = lvt_rdata;
  end
endmodule

// File: rtl/lic_err_unit_chk.sv
module lic_err_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       esr_wr,
  input logic       bad_access,
  input logic       irq_en,
  input logic       acc_rise,
  input logic [7:0] acc_q,
  input logic [7:0] status_q,
  input logic       err_irq
);
  a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_q[4] == 1'b0) && (status_q[4] == 1'b0));

  a_r5_latch_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    esr_wr |=> (status_q == $past(acc_q)));

  a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !esr_wr |=> $stable(status_q));

  a_r9_bad_addr_flag: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |=> acc_q[7]);

  a_r10_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> ((acc_q != 8'h00) && ($past(acc_q) == 8'h00)));

  a_r10_irq_needs_unmask: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |-> $past(irq_en));

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err_irq |=> !err_irq);

  a_r10_rise_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rise && irq_en) |=> err_irq);
endmodule

bind lic_err_unit lic_err_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .esr_wr(esr_wr), .bad_access(bad_access),
  .irq_en(irq_en), .acc_rise(acc_rise), .acc_q(acc_q), .status_q(status_q),
  .err_irq(err_irq)
);

// File: tb/lic_err_unit_bench.sv
module lic_err_unit_bench;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic [3:0]        ev_link = '0;
  logic              tx_valid = 1'b0, rx_valid = 1'b0;
  logic [7:0]        tx_vec = '0, rx_vec = '0;
  logic              err_irq;
  logic [7:0]        err_irq_vec;

  int n_checks = 0;
  int n_fail   = 0;
  logic [7:0] irq_q[$];

  always #10 clk = ~clk;

  lic_err_unit #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_LVT(3), .ILLEGAL_LIMIT(16)) u_lic_err_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ev_link(ev_link), .tx_valid(tx_valid), .tx_vec(tx_vec),
    .rx_valid(rx_valid), .rx_vec(rx_vec), .err_irq(err_irq), .err_irq_vec(err_irq_vec)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0; ev_link = '0; tx_valid = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    tick();
  endtask

  task automatic read_check(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    rd_en = 1'b1; addr = a;
    #1;
    check(tag, rdata, exp);
    tick();
  endtask

  // Latch the accumulator and compare the freshly loaded status
  task automatic latch_check(input logic [7:0] exp, input string tag);
    do_write(0, 32'hFFFF_FFFF);
    read_check(0, {24'h0, exp}, tag);
  endtask

  // Scoreboard monitor: every request must match the next expected vector
  always @(negedge clk) begin
    if (rst_n && err_irq) begin
      n_checks++;
      if (irq_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10 unexpected err_irq actual=0x%02h expected=none", err_irq_vec);
      end else begin
        logic [7:0] e;
        e = irq_q.pop_front();
        if (err_irq_vec !== e) begin
          n_fail++;
          $display("FAIL R10 err_irq_vec actual=0x%02h expected=0x%02h", err_irq_vec, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 err_irq low", {31'h0, err_irq}, 32'h0);
    read_check(0, 32'h0, "R1 status zero");
    read_check(1, 32'h0001_0000, "R1 error entry masked");
    read_check(2, 32'h0001_0000, "R1 source entry masked");
    latch_check(8'h00, "R1 accumulator empty");

    // R2 unmask error entry with legal vector
    do_write(1, 32'h0000_0033);
    read_check(1, 32'h0000_0033, "R2 error entry readback");

    // R4 R10 link events accumulate, one request
    ev_link = 4'b0001; irq_q.push_back(8'h33); tick();
    ev_link = 4'b0100; tick();
    read_check(0, 32'h0, "R4 not visible before write");
    latch_check(8'h05, "R3 R4 accumulated bits 0 and 2");
    latch_check(8'h00, "R5 accumulator cleared by write");

    ev_link = 4'b1010; irq_q.push_back(8'h33); tick();
    latch_check(8'h0A, "R3 receive checksum and accept");

    // R6 R7 illegal vectors
    tx_valid = 1'b1; tx_vec = 8'h0F; irq_q.push_back(8'h33); tick();
    rx_valid = 1'b1; rx_vec = 8'h05; tick();
    latch_check(8'h60, "R6 R7 illegal send and receive");
    tx_valid = 1'b1; tx_vec = 8'h10; tick();
    rx_valid = 1'b1; rx_vec = 8'h10; tick();
    latch_check(8'h00, "R6 vector 16 is legal");

    // R8 entry write with vector zero, masked
    irq_q.push_back(8'h33);
    do_write(2, 32'h0001_0000);
    latch_check(8'h40, "R8 masked zero-vector write flags");
    do_write(4, 32'h0001_0020);
    latch_check(8'h00, "R8 legal vector write no flag");
    read_check(4, 32'h0001_0020, "R2 source entry readback");

    // R9 unimplemented offsets
    irq_q.push_back(8'h33);
    read_check(6, 32'h0, "R9 unimplemented read zero");
    do_write(5, 32'h0000_1234);
    latch_check(8'h80, "R9 illegal address flag");

    // R10 masked entry: recorded, no request
    do_write(1, 32'h0001_0033);
    ev_link = 4'b0001; tick();
    latch_check(8'h01, "R10 masked still records");
    do_write(1, 32'h0001_0000);
    latch_check(8'h40, "R8 error entry zero vector while masked");
    read_check(1, 32'h0001_0000, "R2 error entry readback masked");

    // R5 written data ignored
    do_write(0, 32'h0000_00FF);
    read_check(0, 32'h0, "R5 write data ignored");

    // R3 all sources at once, reserved bit stays zero
    do_write(1, 32'h0000_0045);
    latch_check(8'h00, "R10 unmask with legal vector");
    ev_link = 4'b1111; tx_valid = 1'b1; tx_vec = 8'h00; rx_valid = 1'b1; rx_vec = 8'h0E;
    rd_en = 1'b1; addr = 7; irq_q.push_back(8'h45);
    tick();
    latch_check(8'hEF, "R3 all bits except reserved");

    // R5 event in the same cycle as the status write is kept
    ev_link = 4'b0001; irq_q.push_back(8'h45);
    do_write(0, 32'h0);
    read_check(0, 32'h0, "R5 same-cycle event not in status");
    latch_check(8'h01, "R5 same-cycle event kept");

    repeat (3) tick();
    check("R10 all expected requests seen", irq_q.size(), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule